// File: doc/BRIEF.md
# Cell Fault Qualifier and Latch

This block watches digital comparator outputs for three classes of battery-stack trouble: overvoltage on any cell, undervoltage on any cell, and overtemperature on any thermal input. Each class has its own delay timer, counted in fine steps or in coarse steps. A class must stay active for the programmed number of steps before its status flag is raised. Once raised, the flag holds until the host clears it by writing a one to its bit. If the class's delay is programmed to zero, its flag simply follows the comparators, one clock later, with no latching.

The overvoltage and undervoltage flags are combined into a summary fault bit. The overtemperature flag forms a summary alert bit. Each summary bit is ORed with the matching indication from the device above in the stack, so each output pin reports a condition found here or anywhere higher up.

A single free-running step generator serves all classes. Because of this, the first step of any delay may be partial, and a delay may end up to one step short. Clearing a flag while its condition persists restarts the delay, so a lasting condition raises the flag again after each full delay.

Top module: `fault_monitor`

## Requirements
- R1: After reset, the status bits `status` (bit 0 overvoltage, bit 1 undervoltage, bit 2 overtemperature), both summary bits and both pins are low while `fault_above` and `alert_above` are low.
- R2: With a nonzero delay D and step length S clock cycles, a class's flag stays low for at least (D-1)·S clock edges of continuous activity and is high no later than D·S+1 edges after activity begins.
- R3: If every source of a class goes inactive before its delay expires, the count is discarded, and a new activity period needs a fresh full delay.
- R4: Any single source bit within a class (any cell bit, or either thermal bit) counts as activity for that class.
- R5: The class's coarse select set to 1 makes one step equal `COARSE_MULT` fine steps, where a fine step is `FINE_CYCLES` clock cycles; set to 0, one step is one fine step.
- R6: With a nonzero delay, a raised flag stays high after its sources go inactive, until it is cleared.
- R7: A cycle with `clr_wr` high and a 1 in the class's bit of `clr_data` clears that flag on the next edge. The delay then restarts from zero, so a persisting condition raises the flag again after another delay.
- R8: A 0 in a bit of `clr_data`, or `clr_data` presented while `clr_wr` is low, leaves that flag unchanged.
- R9: When a delay expires in the same cycle as a clear of that class, the flag is set.
- R10: With a class delay of 0, the flag equals that class's source activity one edge earlier, and clear writes have no effect.
- R11: `fault_sum` is the OR of the overvoltage and undervoltage flags, and `alert_sum` is the overtemperature flag. `fault_pin` is `fault_sum` OR `fault_above`, and `alert_pin` is `alert_sum` OR `alert_above`.
- R12: The three classes are independent: activity, timing and clears in one class do not change another class's flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ov_src | input | NUM_CELLS | Per-cell overvoltage comparator outputs |
| uv_src | input | NUM_CELLS | Per-cell undervoltage comparator outputs |
| ot_src | input | NUM_TEMPS | Per-input overtemperature comparator outputs |
| ov_delay | input | DLY_W | Overvoltage delay in steps, 0 = transparent |
| ov_coarse | input | 1 | Overvoltage step select, 1 = coarse |
| uv_delay | input | DLY_W | Undervoltage delay in steps, 0 = transparent |
| uv_coarse | input | 1 | Undervoltage step select, 1 = coarse |
| ot_delay | input | DLY_W | Overtemperature delay in steps, 0 = transparent |
| ot_coarse | input | 1 | Overtemperature step select, 1 = coarse |
| clr_wr | input | 1 | Clear write strobe |
| clr_data | input | 3 | Write-one-to-clear mask, same bit order as `status` |
| fault_above | input | 1 | Fault indication from the device above |
| alert_above | input | 1 | Alert indication from the device above |
| status | output | 3 | Class flags: bit 0 OV, bit 1 UV, bit 2 OT |
| fault_sum | output | 1 | Summary fault bit of this device |
| alert_sum | output | 1 | Summary alert bit of this device |
| fault_pin | output | 1 | Fault output toward the device below |
| alert_pin | output | 1 | Alert output toward the device below |

## Verification
The assertions check several rules on every cycle:
- A held flag is not lost without a clear.
- A clear with no expiry drops the flag.
- An expiry always wins over a clear in the same cycle.
- A transparent class tracks its sources.
- No flag rises without source activity.

Some behaviour can only be shown by the bench's directed scenarios, because it depends on counted time:
- The delay window itself, including its lower and upper bounds.
- The coarse step scaling.
- The discarded count after a short glitch.
- The re-raise of a persistent condition after a clear.
- The stack inputs reaching the pins.

// File: rtl/fm_pkg.sv
// Package: shared class indices for the fault monitor.
// Assumes three fault classes, in a fixed bit order used by status and clear.
package fm_pkg;
    localparam int NUM_CLS = 3;
    localparam int CLS_OV  = 0;
    localparam int CLS_UV  = 1;
    localparam int CLS_OT  = 2;
    typedef logic [NUM_CLS-1:0] cls_vec_t;
endpackage

// File: rtl/fm_step_gen.sv
// Free-running step generator: emits a fine tick every FINE_CYCLES clocks
// and a coarse tick on every COARSE_MULT-th fine tick.
// Assumes FINE_CYCLES >= 2 and COARSE_MULT >= 2.
module fm_step_gen #(
    parameter int FINE_CYCLES = 100,
    parameter int COARSE_MULT = 10
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_fine,
    output logic tick_coarse
);
    localparam int PRE_W = $clog2(FINE_CYCLES);
    localparam int CC_W  = $clog2(COARSE_MULT);
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(FINE_CYCLES - 1);
    localparam logic [CC_W-1:0]  CC_LAST  = CC_W'(COARSE_MULT - 1);

    logic [PRE_W-1:0] pre_q;
    logic [CC_W-1:0]  cc_q;

    assign tick_fine   = (pre_q == PRE_LAST);
    assign tick_coarse = tick_fine && (cc_q == CC_LAST);

    // Prescaler and coarse divider counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= '0;
            cc_q  <= '0;
        end else begin
            pre_q <= tick_fine ? '0 : pre_q + 1'b1;
            if (tick_fine) cc_q <= (cc_q == CC_LAST) ? '0 : cc_q + 1'b1;
        end
    end
endmodule

// File: rtl/fm_class_qual.sv
// One fault class: counts steps while the class is active and latches a flag
// on expiry; clears on a write-one strobe. A delay of 0 makes the flag
// transparent (registered copy of activity, clears ignored).
// Assumes src is already the OR of the class's comparator outputs.
module fm_class_qual #(
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             src,
    input  logic [DLY_W-1:0] delay,
    input  logic             coarse,
    input  logic             tick_fine,
    input  logic             tick_coarse,
    input  logic             clr,
    output logic             flag
);
    logic             enabled;
    logic             step_tick;
    logic             expire;
    logic [DLY_W-1:0] cnt_q;
    logic [DLY_W:0]   cnt_next;
    logic             seen_q;

    // Step selection and expiry detection.
    always_comb begin
        enabled   = (delay != '0);
        step_tick = coarse ? tick_coarse : tick_fine;
        cnt_next  = {1'b0, cnt_q} + 1'b1;
        expire    = enabled && src && !flag && step_tick && (cnt_next >= {1'b0, delay});
    end

    // Flag latch and step counter; expiry takes priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag  <= 1'b0;
            cnt_q <= '0;
        end else if (!enabled) begin
            flag  <= src;
            cnt_q <= '0;
        end else begin
            if (expire)   flag <= 1'b1;
            else if (clr) flag <= 1'b0;
            if (!src || expire)        cnt_q <= '0;
            else if (!flag && step_tick) cnt_q <= cnt_next[DLY_W-1:0];
        end
    end

    // Marks that one edge out of reset has passed, for history-based checks.
    always_ff @(posedge clk) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= 1'b1;
    end

    // R6
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr && enabled) |=> flag);

    // R7
    clear_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !expire && enabled) |=> !flag);

    // R9
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> flag);

    // R10
    transparent_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && $past(delay) == '0) |-> (flag == $past(src)));

    // R2
    no_idle_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && $rose(flag)) |-> $past(src));
endmodule

// File: rtl/fault_monitor.sv
// Top: three qualified fault classes, summary bits and stacked output pins.
// Assumes comparator outputs are synchronous to clk; clear strobe is one
// write cycle with a bit mask in status bit order.
module fault_monitor #(
    parameter int NUM_CELLS   = 6,
    parameter int NUM_TEMPS   = 2,
    parameter int DLY_W       = 8,
    parameter int FINE_CYCLES = 100,
    parameter int COARSE_MULT = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_CELLS-1:0] ov_src,
    input  logic [NUM_CELLS-1:0] uv_src,
    input  logic [NUM_TEMPS-1:0] ot_src,
    input  logic [DLY_W-1:0]     ov_delay,
    input  logic                 ov_coarse,
    input  logic [DLY_W-1:0]     uv_delay,
    input  logic                 uv_coarse,
    input  logic [DLY_W-1:0]     ot_delay,
    input  logic                 ot_coarse,
    input  logic                 clr_wr,
    input  logic [2:0]           clr_data,
    input  logic                 fault_above,
    input  logic                 alert_above,
    output logic [2:0]           status,
    output logic                 fault_sum,
    output logic                 alert_sum,
    output logic                 fault_pin,
    output logic                 alert_pin
);
    import fm_pkg::*;

    logic tick_fine, tick_coarse;
    cls_vec_t                      cls_src, cls_coarse, cls_clr, cls_flag;
    logic [NUM_CLS-1:0][DLY_W-1:0] cls_delay;

    // Per-class source activity, configuration and clear routing.
    always_comb begin
        cls_src[CLS_OV]    = |ov_src;
        cls_src[CLS_UV]    = |uv_src;
        cls_src[CLS_OT]    = |ot_src;
        cls_delay[CLS_OV]  = ov_delay;
        cls_delay[CLS_UV]  = uv_delay;
        cls_delay[CLS_OT]  = ot_delay;
        cls_coarse[CLS_OV] = ov_coarse;
        cls_coarse[CLS_UV] = uv_coarse;
        cls_coarse[CLS_OT] = ot_coarse;
        cls_clr            = clr_wr ? clr_data : '0;
    end

    fm_step_gen #(
        .FINE_CYCLES(FINE_CYCLES),
        .COARSE_MULT(COARSE_MULT)
    ) u_steps (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_fine  (tick_fine),
        .tick_coarse(tick_coarse)
    );

    for (genvar c = 0; c < NUM_CLS; c++) begin : g_cls
        fm_class_qual #(.DLY_W(DLY_W)) u_qual (
            .clk        (clk),
            .rst_n      (rst_n),
            .src        (cls_src[c]),
            .delay      (cls_delay[c]),
            .coarse     (cls_coarse[c]),
            .tick_fine  (tick_fine),
            .tick_coarse(tick_coarse),
            .clr        (cls_clr[c]),
            .flag       (cls_flag[c])
        );
    end

    // Status, summary and stacked pin outputs.
    always_comb begin
        status    = cls_flag;
        fault_sum = cls_flag[CLS_OV] | cls_flag[CLS_UV];
        alert_sum = cls_flag[CLS_OT];
        fault_pin = fault_sum | fault_above;
        alert_pin = alert_sum | alert_above;
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (status == '0));
endmodule

// File: tb/fault_monitor_test.sv
module fault_monitor_test;
    localparam int CLK_PERIOD = 10;
    localparam int NC = 6, NT = 2, DW = 8, FC = 4, CM = 5;

    logic clk = 0, rst_n = 0;
    logic [NC-1:0] ov_src = 0, uv_src = 0;
    logic [NT-1:0] ot_src = 0;
    logic [DW-1:0] ov_delay = 0, uv_delay = 0, ot_delay = 0;
    logic ov_coarse = 0, uv_coarse = 0, ot_coarse = 0;
    logic clr_wr = 0;
    logic [2:0] clr_data = 0;
    logic fault_above = 0, alert_above = 0;
    logic [2:0] status;
    logic fault_sum, alert_sum, fault_pin, alert_pin;
    int checks = 0, errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fault_monitor #(.NUM_CELLS(NC), .NUM_TEMPS(NT), .DLY_W(DW),
                    .FINE_CYCLES(FC), .COARSE_MULT(CM)) uut (
        .clk(clk), .rst_n(rst_n), .ov_src(ov_src), .uv_src(uv_src), .ot_src(ot_src),
        .ov_delay(ov_delay), .ov_coarse(ov_coarse), .uv_delay(uv_delay),
        .uv_coarse(uv_coarse), .ot_delay(ot_delay), .ot_coarse(ot_coarse),
        .clr_wr(clr_wr), .clr_data(clr_data), .fault_above(fault_above),
        .alert_above(alert_above), .status(status), .fault_sum(fault_sum),
        .alert_sum(alert_sum), .fault_pin(fault_pin), .alert_pin(alert_pin));

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic clear_all();
        ov_src = 0; uv_src = 0; ot_src = 0;
        ov_delay = 1; uv_delay = 1; ot_delay = 1;
        clr_wr = 1; clr_data = 3'b111;
        edges(1);
        clr_wr = 0; clr_data = 0;
        edges(1);
    endtask

    task automatic t_reset();
        check("R1 status", {5'b0, status}, 8'h00);
        check("R1 pins", {4'b0, fault_sum, alert_sum, fault_pin, alert_pin}, 8'h00);
    endtask

    task automatic t_fine_delay_latch();
        clear_all();
        ov_delay = 3;
        ov_src = 6'b000100;
        edges(8);
        check("R2 early low", {5'b0, status}, 8'h00);
        edges(5);
        check("R2 raised by limit", {5'b0, status}, 8'h01);
        check("R11 fault_sum", {6'b0, fault_sum, fault_pin}, 8'h03);
        ov_src = 0;
        edges(3);
        check("R6 held after source gone", {5'b0, status}, 8'h01);
        clr_wr = 1; clr_data = 3'b000;
        edges(1);
        check("R8 zero bit no effect", {5'b0, status}, 8'h01);
        clr_wr = 0; clr_data = 3'b001;
        edges(1);
        check("R8 no strobe no effect", {5'b0, status}, 8'h01);
        clr_wr = 1;
        edges(1);
        clr_wr = 0; clr_data = 0;
        check("R7 cleared", {5'b0, status}, 8'h00);
        edges(20);
        check("R7 stays clear when idle", {5'b0, status}, 8'h00);
    endtask

    task automatic t_persistent_reraise();
        clear_all();
        ov_delay = 3;
        ov_src = 6'b100000;
        edges(13);
        check("R7 first raise", {5'b0, status}, 8'h01);
        clr_wr = 1; clr_data = 3'b001;
        edges(1);
        clr_wr = 0; clr_data = 0;
        check("R7 clear while active", {5'b0, status}, 8'h00);
        edges(8);
        check("R7 timer restarted", {5'b0, status}, 8'h00);
        edges(5);
        check("R7 re-raised", {5'b0, status}, 8'h01);
    endtask

    task automatic t_glitch_restart();
        clear_all();
        uv_delay = 4;
        uv_src = 6'b000010;
        edges(10);
        check("R3 not yet", {5'b0, status}, 8'h00);
        uv_src = 0;
        edges(2);
        uv_src = 6'b010000;
        edges(12);
        check("R3 count discarded", {5'b0, status}, 8'h00);
        edges(5);
        check("R4 other cell bit raises UV", {5'b0, status}, 8'h02);
    endtask

    task automatic t_coarse();
        clear_all();
        ot_delay = 2; ot_coarse = 1;
        ot_src = 2'b10;
        edges(20);
        check("R5 coarse early low", {5'b0, status}, 8'h00);
        edges(21);
        check("R5 coarse raised", {5'b0, status}, 8'h04);
        check("R11 alert only", {4'b0, fault_sum, alert_sum, fault_pin, alert_pin}, 8'h05);
        ot_src = 0;
        clr_wr = 1; clr_data = 3'b011;
        edges(1);
        clr_wr = 0; clr_data = 0;
        check("R12 other-class clear keeps OT", {5'b0, status}, 8'h04);
        ot_coarse = 0;
    endtask

    task automatic t_transparent();
        clear_all();
        ov_delay = 0;
        ov_src = 6'b000001;
        edges(1);
        check("R10 follows on", {5'b0, status}, 8'h01);
        clr_wr = 1; clr_data = 3'b001;
        edges(1);
        clr_wr = 0; clr_data = 0;
        check("R10 clear ignored", {5'b0, status}, 8'h01);
        ov_src = 0;
        edges(1);
        check("R10 follows off", {5'b0, status}, 8'h00);
    endtask

    task automatic t_set_priority();
        int highs = 0;
        clear_all();
        ov_delay = 2;
        ov_src = 6'b001000;
        clr_wr = 1; clr_data = 3'b001;
        for (int i = 0; i < 40; i++) begin
            edges(1);
            if (status[0]) highs++;
        end
        clr_wr = 0; clr_data = 0;
        check("R9 set seen despite constant clear", {7'b0, highs > 0}, 8'h01);
    endtask

    task automatic t_stack_inputs();
        clear_all();
        fault_above = 1; alert_above = 0;
        #1;
        check("R11 fault from above", {4'b0, fault_sum, alert_sum, fault_pin, alert_pin}, 8'h02);
        fault_above = 0; alert_above = 1;
        #1;
        check("R11 alert from above", {4'b0, fault_sum, alert_sum, fault_pin, alert_pin}, 8'h01);
        alert_above = 0;
    endtask

    initial begin
        fork
            begin
                edges(3);
                rst_n = 1;
                edges(1);
                t_reset();
                t_fine_delay_latch();
                t_persistent_reraise();
                t_glitch_restart();
                t_coarse();
                t_transparent();
                t_set_priority();
                t_stack_inputs();
            end
            begin
                repeat (20000) @(posedge clk);
                errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule